// File: doc/BRIEF.md
# Atomic Read-Modify-Write Value Unit

This block is the arithmetic core of an atomic read-modify-write path. It takes the value just read from memory, the register operand supplied with the request, an operation code, a size code and the low address bits. From these it forms two values in the same cycle. The first is the data to write back to memory, with a byte-lane enable mask. The second is the value returned to the destination register. It has no registers: a memory sequencer samples its outputs when it has both operands in hand.

Before the operation is applied, both operands are cut to the access size and widened to the full register width. Only the two unsigned compare operations widen with zeros. All other operations widen with the sign bit. The returned value always comes from the loaded data, sign-widened from the access size, whatever the operation. Register width is a parameter that may be 32 or 64.

Top module: `amo_compute_unit`

## Requirements
- R1: Operation code 0 (swap) writes the register operand, cut to the access size, as the new memory value.
- R2: Operation code 1 (add) writes the two's-complement sum of the two widened operands, wrapping at the register width.
- R3: Operation codes 2, 3 and 4 write the bitwise xor, and, and or of the two operands.
- R4: Operation codes 5 (signed minimum) and 6 (signed maximum) sign-widen both operands from the access size and compare them as signed integers.
- R5: Operation codes 7 (unsigned minimum) and 8 (unsigned maximum) zero-widen both operands from the access size and compare them as unsigned integers.
- R6: Size codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. Register operand bits above the access size have no effect on any output.
- R7: `ret_data` is the loaded value sign-widened from the access size for every operation code, the unsigned ones included.
- R8: `store_data` carries the low access-size bits of the result in its least significant bytes, with all higher bits zero.
- R9: `byte_en` has one bit per byte lane. It is a run of 1, 2, 4 or 8 ones, set by the size code, shifted left by `addr_lo`. Lanes shifted past the top are dropped.
- R10: Operation codes 9 to 15 raise `err` and force `store_data`, `byte_en` and `ret_data` to zero.
- R11: Size code 3 is legal only when the register width is 64. With a 32-bit register width it raises `err` and forces the outputs to zero, as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ld_data | input | XLEN | Value read from memory, right-aligned |
| reg_data | input | XLEN | Register operand of the request |
| op | input | 4 | Operation code |
| size | input | 2 | Access size code |
| addr_lo | input | clog2(XLEN/8) | Byte offset within the register-wide word |
| store_data | output | XLEN | New memory value, right-aligned |
| byte_en | output | XLEN/8 | Byte-lane write mask |
| ret_data | output | XLEN | Value for the destination register |
| err | output | 1 | Illegal operation code or size |

## Verification
The hardest case is a narrow compare in which the opcode's signedness and the sign bit of the access size disagree. For example, a byte of 0x80 against 0x01 gives opposite answers for signed and unsigned minimum, and sign-widening the return value for an unsigned maximum still has to fill ones. The stimulus drives the same operand pair through both the signed and the unsigned compares at byte and word sizes. It also places the sign bits just at the access boundary with junk above it in the register operand. A second instance at 32-bit width reaches the illegal double size.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [3:0] {
        AOP_SWAP = 4'd0,
        AOP_ADD  = 4'd1,
        AOP_XOR  = 4'd2,
        AOP_AND  = 4'd3,
        AOP_OR   = 4'd4,
        AOP_MIN  = 4'd5,
        AOP_MAX  = 4'd6,
        AOP_MINU = 4'd7,
        AOP_MAXU = 4'd8
    } amo_op_e;

    typedef enum logic [1:0] {
        ASZ_8  = 2'd0,
        ASZ_16 = 2'd1,
        ASZ_32 = 2'd2,
        ASZ_64 = 2'd3
    } amo_size_e;

    typedef struct packed {
        logic op_ok;
        logic size_ok;
        logic zext;
    } amo_ctrl_t;

    localparam int unsigned AOP_LAST = 8;

    function automatic logic op_is_known(input logic [3:0] code);
        return code <= 4'(AOP_LAST);
    endfunction

    function automatic logic op_is_unsigned(input logic [3:0] code);
        return (code == AOP_MINU) || (code == AOP_MAXU);
    endfunction

    function automatic int unsigned size_bytes(input logic [1:0] sz);
        return 32'd1 << sz;
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0] op,
    input  logic [1:0] size,
    output amo_ctrl_t  ctrl
);
    localparam bit WIDE_OK = (XLEN == 64);

    always_comb begin
        ctrl.op_ok   = op_is_known(op);
        ctrl.zext    = op_is_unsigned(op);
        ctrl.size_ok = (size != ASZ_64) || WIDE_OK;
    end
endmodule

// File: rtl/amo_operand_ext.sv
module amo_operand_ext
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] din,
    input  logic [1:0]      size,
    input  logic            zext,
    output logic [XLEN-1:0] dout
);
    always_comb begin
        case (size)
            ASZ_8:   dout = {{(XLEN-8){din[7] & ~zext}}, din[7:0]};
            ASZ_16:  dout = {{(XLEN-16){din[15] & ~zext}}, din[15:0]};
            ASZ_32: begin
                if (XLEN > 32) dout = {{(XLEN-32){din[31] & ~zext}}, din[31:0]};
                else           dout = din;
            end
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] mem_v,
    input  logic [XLEN-1:0] reg_v,
    output logic [XLEN-1:0] result
);
    logic s_lt;
    logic u_lt;

    always_comb begin
        s_lt = $signed(reg_v) < $signed(mem_v);
        u_lt = reg_v < mem_v;
        case (op)
            AOP_SWAP: result = reg_v;
            AOP_ADD:  result = reg_v + mem_v;
            AOP_XOR:  result = reg_v ^ mem_v;
            AOP_AND:  result = reg_v & mem_v;
            AOP_OR:   result = reg_v | mem_v;
            AOP_MIN:  result = s_lt ? reg_v : mem_v;
            AOP_MAX:  result = s_lt ? mem_v : reg_v;
            AOP_MINU: result = u_lt ? reg_v : mem_v;
            AOP_MAXU: result = u_lt ? mem_v : reg_v;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/amo_store_pack.sv
module amo_store_pack
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]          result,
    input  logic [1:0]               size,
    input  logic [$clog2(XLEN/8)-1:0] addr_lo,
    output logic [XLEN-1:0]          data,
    output logic [XLEN/8-1:0]        lanes
);
    localparam int NB = XLEN / 8;

    logic [NB-1:0]   base;
    logic [2*NB-1:0] wide;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            base[i] = (i < int'(size_bytes(size)));
        end
        wide  = {{NB{1'b0}}, base} << addr_lo;
        lanes = wide[NB-1:0];
        data  = '0;
        for (int b = 0; b < NB; b++) begin
            if (base[b]) data[8*b +: 8] = result[8*b +: 8];
        end
    end
endmodule

// File: rtl/amo_compute_unit.sv
module amo_compute_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]           ld_data,
    input  logic [XLEN-1:0]           reg_data,
    input  logic [3:0]                op,
    input  logic [1:0]                size,
    input  logic [$clog2(XLEN/8)-1:0] addr_lo,
    output logic [XLEN-1:0]           store_data,
    output logic [XLEN/8-1:0]         byte_en,
    output logic [XLEN-1:0]           ret_data,
    output logic                      err
);
    localparam int NB = XLEN / 8;

    amo_ctrl_t       ctrl;
    logic [XLEN-1:0] mem_x;
    logic [XLEN-1:0] reg_x;
    logic [XLEN-1:0] ret_x;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] pk_data;
    logic [NB-1:0]   pk_lanes;

    amo_decode #(.XLEN(XLEN)) u_dec (
        .op   (op),
        .size (size),
        .ctrl (ctrl)
    );

    amo_operand_ext #(.XLEN(XLEN)) u_ext_mem (
        .din (ld_data), .size (size), .zext (ctrl.zext), .dout (mem_x)
    );

    amo_operand_ext #(.XLEN(XLEN)) u_ext_reg (
        .din (reg_data), .size (size), .zext (ctrl.zext), .dout (reg_x)
    );

    amo_operand_ext #(.XLEN(XLEN)) u_ext_ret (
        .din (ld_data), .size (size), .zext (1'b0), .dout (ret_x)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op     (op),
        .mem_v  (mem_x),
        .reg_v  (reg_x),
        .result (alu_y)
    );

    amo_store_pack #(.XLEN(XLEN)) u_pack (
        .result  (alu_y),
        .size    (size),
        .addr_lo (addr_lo),
        .data    (pk_data),
        .lanes   (pk_lanes)
    );

    always_comb begin
        err        = ~(ctrl.op_ok & ctrl.size_ok);
        store_data = err ? '0 : pk_data;
        byte_en    = err ? '0 : pk_lanes;
        ret_data   = err ? '0 : ret_x;
    end
endmodule

// File: rtl/amo_compute_chk.sv
module amo_compute_chk #(
    parameter int XLEN = 64
) (
    input logic [XLEN-1:0]           ld_data,
    input logic [XLEN-1:0]           reg_data,
    input logic [3:0]                op,
    input logic [1:0]                size,
    input logic [$clog2(XLEN/8)-1:0] addr_lo,
    input logic [XLEN-1:0]           store_data,
    input logic [XLEN/8-1:0]         byte_en,
    input logic [XLEN-1:0]           ret_data,
    input logic                      err
);
    logic [XLEN-1:0] keep;
    logic            ret_ok;

    always_comb begin
        case (size)
            2'd0:    keep = XLEN'(64'hFF);
            2'd1:    keep = XLEN'(64'hFFFF);
            2'd2:    keep = XLEN'(64'hFFFF_FFFF);
            default: keep = '1;
        endcase
        case (size)
            2'd0:    ret_ok = (ret_data[7:0] == ld_data[7:0]) &&
                              (ret_data[XLEN-1:8] == {(XLEN-8){ld_data[7]}});
            2'd1:    ret_ok = (ret_data[15:0] == ld_data[15:0]) &&
                              (ret_data[XLEN-1:16] == {(XLEN-16){ld_data[15]}});
            default: ret_ok = ((ret_data & keep) == (ld_data & keep));
        endcase
    end

    always_comb begin
        if (err) begin
            a_r10_err_quiet: assert (store_data == '0 && byte_en == '0 && ret_data == '0);
        end
        if (op > 4'd8) begin
            a_r10_bad_op_flags: assert (err);
        end
        if (!err) begin
            a_r9_lane_count: assert ($countones(byte_en) <= (1 << size));
            a_r8_upper_zero: assert ((store_data & ~keep) == '0);
            a_r7_ret_sign: assert (ret_ok);
        end
        if (!err && op == 4'd0) begin
            a_r1_swap_copy: assert (((store_data ^ reg_data) & keep) == '0);
        end
        if (XLEN == 32 && size == 2'd3) begin
            a_r11_wide_illegal: assert (err);
        end
    end
endmodule

bind amo_compute_unit amo_compute_chk #(.XLEN(XLEN)) u_chk (
    .ld_data    (ld_data),
    .reg_data   (reg_data),
    .op         (op),
    .size       (size),
    .addr_lo    (addr_lo),
    .store_data (store_data),
    .byte_en    (byte_en),
    .ret_data   (ret_data),
    .err        (err)
);

// File: tb/sim_amo_compute_unit.sv
module sim_amo_compute_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    logic [63:0] ld, rg, st, rt;
    logic [3:0]  op;
    logic [1:0]  sz;
    logic [2:0]  al;
    logic [7:0]  be;
    logic        er;

    amo_compute_unit #(.XLEN(64)) u0 (
        .ld_data (ld), .reg_data (rg), .op (op), .size (sz), .addr_lo (al),
        .store_data (st), .byte_en (be), .ret_data (rt), .err (er)
    );

    logic [31:0] ld32, rg32, st32, rt32;
    logic [3:0]  op32;
    logic [1:0]  sz32;
    logic [1:0]  al32;
    logic [3:0]  be32;
    logic        er32;

    amo_compute_unit #(.XLEN(32)) u1 (
        .ld_data (ld32), .reg_data (rg32), .op (op32), .size (sz32), .addr_lo (al32),
        .store_data (st32), .byte_en (be32), .ret_data (rt32), .err (er32)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [1:0] s, input logic [2:0] a,
                         input logic [63:0] l, input logic [63:0] r);
        @(negedge clk);
        op = o; sz = s; al = a; ld = l; rg = r;
        @(posedge clk);
        #2;
    endtask

    task automatic expect64(input string req, input logic [63:0] es, input logic [7:0] eb,
                            input logic [63:0] er_v, input logic ee);
        chk({req, " store"}, st, es);
        chk({req, " lanes"}, {56'd0, be}, {56'd0, eb});
        chk({req, " ret"}, rt, er_v);
        chk({req, " err"}, {63'd0, er}, {63'd0, ee});
    endtask

    task automatic t_reset_idle;
        apply(4'd0, 2'd0, 3'd0, 64'd0, 64'd0);
        expect64("R8 idle", 64'd0, 8'h01, 64'd0, 1'b0);
    endtask

    task automatic t_swap;
        apply(4'd0, 2'd0, 3'd0, 64'h0000_0000_0000_00FF, 64'h1234_5678_9ABC_DEF0);
        expect64("R1 swap byte", 64'hF0, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        apply(4'd0, 2'd1, 3'd2, 64'h0, 64'hDEAD_BEEF_0000_1234);
        expect64("R6 swap half upper junk", 64'h1234, 8'h0C, 64'h0, 1'b0);
    endtask

    task automatic t_add;
        apply(4'd1, 2'd2, 3'd4, 64'h0000_0000_7FFF_FFFF, 64'hAAAA_AAAA_0000_0001);
        expect64("R2 add word", 64'h8000_0000, 8'hF0, 64'h7FFF_FFFF, 1'b0);
        apply(4'd1, 2'd3, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2);
        expect64("R2 add double wrap", 64'h1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    endtask

    task automatic t_logic;
        apply(4'd2, 2'd1, 3'd0, 64'h00F0, 64'hFF0F);
        expect64("R3 xor half", 64'hFFFF, 8'h03, 64'h00F0, 1'b0);
        apply(4'd3, 2'd1, 3'd2, 64'h00F0, 64'hFF0F);
        expect64("R3 and half", 64'h0, 8'h0C, 64'h00F0, 1'b0);
        apply(4'd4, 2'd0, 3'd7, 64'h0F, 64'hF0);
        expect64("R3 or byte", 64'hFF, 8'h80, 64'h0F, 1'b0);
    endtask

    task automatic t_signed_cmp;
        apply(4'd5, 2'd0, 3'd0, 64'h01, 64'hFFFF_FF00_0000_0080);
        expect64("R4 min byte", 64'h80, 8'h01, 64'h01, 1'b0);
        apply(4'd6, 2'd0, 3'd0, 64'h01, 64'h80);
        expect64("R4 max byte", 64'h01, 8'h01, 64'h01, 1'b0);
        apply(4'd6, 2'd2, 3'd0, 64'h8000_0000, 64'h7FFF_FFFF);
        expect64("R4 max word", 64'h7FFF_FFFF, 8'h0F, 64'hFFFF_FFFF_8000_0000, 1'b0);
        apply(4'd5, 2'd3, 3'd0, 64'h8000_0000_0000_0000, 64'h1);
        expect64("R4 min double", 64'h8000_0000_0000_0000, 8'hFF, 64'h8000_0000_0000_0000, 1'b0);
    endtask

    task automatic t_unsigned_cmp;
        apply(4'd7, 2'd0, 3'd0, 64'h01, 64'h80);
        expect64("R5 minu byte", 64'h01, 8'h01, 64'h01, 1'b0);
        apply(4'd8, 2'd0, 3'd1, 64'h80, 64'h01);
        expect64("R7 maxu byte ret sign", 64'h80, 8'h02, 64'hFFFF_FFFF_FFFF_FF80, 1'b0);
        apply(4'd8, 2'd2, 3'd0, 64'h8000_0000, 64'h7FFF_FFFF);
        expect64("R5 maxu word", 64'h8000_0000, 8'h0F, 64'hFFFF_FFFF_8000_0000, 1'b0);
        apply(4'd7, 2'd3, 3'd0, 64'h8000_0000_0000_0000, 64'h1);
        expect64("R5 minu double", 64'h1, 8'hFF, 64'h8000_0000_0000_0000, 1'b0);
    endtask

    task automatic t_lanes_edge;
        apply(4'd0, 2'd2, 3'd6, 64'h0, 64'h0);
        expect64("R9 word lanes dropped", 64'h0, 8'hC0, 64'h0, 1'b0);
    endtask

    task automatic t_bad_op;
        for (int c = 9; c < 16; c++) begin
            apply(4'(c), 2'd0, 3'd0, 64'h80, 64'h55);
            expect64("R10 bad opcode", 64'h0, 8'h00, 64'h0, 1'b1);
        end
    endtask

    task automatic t_narrow_width;
        @(negedge clk);
        op32 = 4'd1; sz32 = 2'd3; al32 = 2'd0; ld32 = 32'h5; rg32 = 32'h7;
        @(posedge clk); #2;
        chk("R11 double on 32 err", {63'd0, er32}, 64'd1);
        chk("R11 double on 32 store", {32'd0, st32}, 64'd0);
        chk("R11 double on 32 lanes", {60'd0, be32}, 64'd0);
        @(negedge clk);
        sz32 = 2'd2;
        @(posedge clk); #2;
        chk("R11 word on 32 err", {63'd0, er32}, 64'd0);
        chk("R2 word on 32 store", {32'd0, st32}, 64'd12);
        chk("R9 word on 32 lanes", {60'd0, be32}, 64'hF);
    endtask

    initial begin
        op = '0; sz = '0; al = '0; ld = '0; rg = '0;
        op32 = '0; sz32 = '0; al32 = '0; ld32 = '0; rg32 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_idle();
        t_swap();
        t_add();
        t_logic();
        t_signed_cmp();
        t_unsigned_cmp();
        t_lanes_edge();
        t_bad_op();
        t_narrow_width();
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule